// File: doc/BRIEF.md
# Byte-Loaded Serial Word Transmitter

This block takes a 32-bit data word from a host as four 8-bit bytes over a parallel write port. It then sends the word serially at one bit per transmit-clock period. A gap of four idle bit periods follows every word. The block drives two return-to-zero pulse outputs, one for "1" bits and one for "0" bits. It also drives a non-return serial data line and an active-low sync pulse that marks bit 8 of each word.

A byte buffer sits in front of the output shift register. The host can therefore load the next word while the current one is still going out. A ready flag shows when that buffer may take a new word. The block runs entirely on the transmit clock. The write strobe is asynchronous and is brought into the clock domain by a synchronizer. Bit 32 can carry odd parity in place of the last data bit.

Top module: `arinc_word_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `buf_ready` is 1, `line_one`, `line_zero` and `ser_data` are 0, and `sync_n` is 1. Only gap is sent until a complete word has been loaded. Asserting `rst_n` during a transmission aborts that transmission at once.
- R2: A byte on `din` is captured on the rising edge of `wr_n`. The capture lands at the third `tx_clk` rising edge after the strobe rises. A byte written with `first_sel`=1 becomes byte 1 (the label) and restarts the byte count, even in the middle of a word. Bytes 2, 3 and 4 follow in order with `first_sel`=0.
- R3: `buf_ready` goes to 0 at the same clock edge that captures the fourth byte.
- R4: If nothing is being transmitted, the buffered word moves to the shifter at the next `tx_clk` edge after the fourth byte is captured. Bit 1 is sent in the period that follows, and `buf_ready` returns to 1 at that same edge.
- R5: If a word is still being sent, the buffered word moves at the edge that closes the fourth gap bit. The new word therefore follows exactly four gap periods, `buf_ready` stays 0 until that edge, and it returns to 1 there.
- R6: Byte 1 is sent first, then bytes 2, 3 and 4. With the default `LSB_FIRST`=1, each byte is sent least-significant bit first.
- R7: With `par_en`=1 at the transfer, bit 32 is set so that the 32 sent bits hold an odd number of ones. With `par_en`=0, bit 32 is bit 7 of byte 4.
- R8: `line_one` is high while `tx_clk` is high during a bit period that sends a 1. `line_zero` is high while `tx_clk` is high during a bit period that sends a 0. Both are low in the second half of every bit period and throughout the gap, and they are never high together.
- R9: `ser_data` holds the value of the bit being sent for the whole bit period, and it is 0 during the gap.
- R10: `sync_n` is 0 only while `tx_clk` is low during bit 8 of a word.
- R11: A byte with `first_sel`=0 that arrives before any label byte of the current word is ignored. Any write while `buf_ready` is 0 is ignored and leaves the buffered word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock; one bit per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Write strobe, captures on its rising edge (asynchronous) |
| first_sel | input | 1 | 1 marks the label byte, 0 marks bytes 2 to 4 |
| din | input | 8 | Byte being written |
| par_en | input | 1 | 1 replaces bit 32 with odd parity |
| buf_ready | output | 1 | 1 when the byte buffer may take a word |
| line_one | output | 1 | Return-to-zero pulse for each 1 bit |
| line_zero | output | 1 | Return-to-zero pulse for each 0 bit |
| ser_data | output | 1 | Serial bit stream, held for the full period |
| sync_n | output | 1 | Active-low pulse in the low half of bit 8 |

## Verification
A strobe rise becomes a registered byte at the third rising edge of `tx_clk`. `buf_ready` falls at that same edge for the fourth byte. The bench holds `din` until it has seen three falling edges and reads `buf_ready` right after the third.

When the block is idle, bit 1 is due in the period that starts at the fourth edge. When a word is still going out, the next one starts at the edge that closes gap bit 4. The bench samples pulse and data outputs 1 ns after each rising edge, where the first half-period value is set. It samples the low-half values (pulses cleared, `sync_n`) 1 ns after each falling edge, so every bit is checked in the half-period it belongs to.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int NBYTES = 4;
  localparam int WORD_W = BYTE_W * NBYTES;

  typedef logic [NBYTES-1:0][BYTE_W-1:0] bytes_t;
  typedef logic [WORD_W-1:0]             word_t;

  // Serial order: element k is the k-th bit on the line.
  function automatic word_t order_bits(input bytes_t b, input logic lsb_first);
    word_t s;
    for (int i = 0; i < NBYTES; i++) begin
      for (int j = 0; j < BYTE_W; j++) begin
        s[i*BYTE_W + j] = lsb_first ? b[i][j] : b[i][BYTE_W-1-j];
      end
    end
    return s;
  endfunction

  // Bit that makes the full word carry an odd count of ones.
  function automatic logic odd_fill(input logic [WORD_W-2:0] head);
    return ~(^head);
  endfunction

  function automatic word_t finish_word(input word_t s, input logic par);
    word_t r;
    r = s;
    if (par) r[WORD_W-1] = odd_fill(s[WORD_W-2:0]);
    return r;
  endfunction
endpackage

// File: rtl/arinc_wr_sync.sv
module arinc_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic wr_rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= wr_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], wr_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign wr_rise = chain_q[STAGES-1] & ~prev_q;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> !wr_rise) else $error("R2: strobe pulse longer than one cycle");
endmodule

// File: rtl/arinc_load_buf.sv
module arinc_load_buf
  import arinc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rise,
  input  logic              first_sel,
  input  logic [BYTE_W-1:0] din,
  input  logic              take,
  output bytes_t            buf_bytes,
  output logic              full,
  output logic              fourth_ev
);
  localparam int CNT_W = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES-1);

  logic [CNT_W-1:0] cnt_q;   // 0: no label seen for this word
  bytes_t           bytes_q;
  logic             full_q;
  logic             accept;

  assign accept    = wr_rise && !full_q;
  assign fourth_ev = accept && !first_sel && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bytes_q <= '0;
      full_q  <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (accept) begin
        if (first_sel) begin
          bytes_q[0] <= din;
          cnt_q      <= CNT_W'(1);
        end else if (cnt_q != '0) begin
          bytes_q[cnt_q] <= din;
          if (cnt_q == LAST_IDX) begin
            full_q <= 1'b1;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign buf_bytes = bytes_q;
  assign full      = full_q;

  a_r3_full_on_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    fourth_ev |=> full_q) else $error("R3: fourth byte did not fill buffer");
  a_r11_locked_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && full_q) |=> $stable(bytes_q)) else $error("R11: full buffer changed");
  a_r11_orphan_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !full_q && !first_sel && cnt_q == '0) |=> ($stable(bytes_q) && cnt_q == '0))
    else $error("R11: byte without label accepted");
endmodule

// File: rtl/arinc_bit_seq.sv
module arinc_bit_seq
  import arinc_tx_pkg::*;
#(
  parameter int GAP_BITS  = 4,
  parameter int SYNC_BIT  = 8,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   full,
  input  bytes_t buf_bytes,
  input  logic   par_en,
  output logic   xfer,
  output logic   data_slot,
  output logic   cur_bit,
  output logic   sync_slot
);
  localparam int LAST_SLOT = WORD_W + GAP_BITS - 1;
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(LAST_SLOT);
  localparam logic [SLOT_W-1:0] WORD_S = SLOT_W'(WORD_W);
  localparam logic [SLOT_W-1:0] SYNC_S = SLOT_W'(SYNC_BIT - 1);

  logic              active_q;
  logic [SLOT_W-1:0] slot_q;
  word_t             shreg_q;
  logic              at_end;

  assign at_end = !active_q || (slot_q == LAST_S);
  assign xfer   = at_end && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      shreg_q  <= '0;
    end else if (at_end) begin
      slot_q <= '0;
      if (full) begin
        shreg_q  <= finish_word(order_bits(buf_bytes, 1'(LSB_FIRST)), par_en);
        active_q <= 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end else begin
      slot_q  <= slot_q + SLOT_W'(1);
      shreg_q <= shreg_q >> 1;
    end
  end

  assign data_slot = active_q && (slot_q < WORD_S);
  assign cur_bit   = shreg_q[0];
  assign sync_slot = data_slot && (slot_q == SYNC_S);

  a_r5_xfer_only_at_gap_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (!active_q || slot_q == LAST_S)) else $error("R5: transfer mid-word");
  a_r4_bit1_follows_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (data_slot && slot_q == '0)) else $error("R4: bit 1 not started");
  a_r5_busy_holds_full: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && slot_q != LAST_S && full) |=> full) else $error("R5: early transfer");
endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx
  import arinc_tx_pkg::*;
#(
  parameter int GAP_BITS    = 4,
  parameter int SYNC_BIT    = 8,
  parameter bit LSB_FIRST   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tx_clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              first_sel,
  input  logic [BYTE_W-1:0] din,
  input  logic              par_en,
  output logic              buf_ready,
  output logic              line_one,
  output logic              line_zero,
  output logic              ser_data,
  output logic              sync_n
);
  logic   wr_rise;
  logic   xfer;
  logic   full;
  logic   fourth_ev;
  logic   data_slot;
  logic   cur_bit;
  logic   sync_slot;
  bytes_t buf_bytes;

  arinc_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(tx_clk), .rst_n(rst_n), .wr_n(wr_n), .wr_rise(wr_rise)
  );

  arinc_load_buf u_buf (
    .clk(tx_clk), .rst_n(rst_n), .wr_rise(wr_rise), .first_sel(first_sel),
    .din(din), .take(xfer), .buf_bytes(buf_bytes), .full(full),
    .fourth_ev(fourth_ev)
  );

  arinc_bit_seq #(.GAP_BITS(GAP_BITS), .SYNC_BIT(SYNC_BIT), .LSB_FIRST(LSB_FIRST)) u_seq (
    .clk(tx_clk), .rst_n(rst_n), .full(full), .buf_bytes(buf_bytes),
    .par_en(par_en), .xfer(xfer), .data_slot(data_slot), .cur_bit(cur_bit),
    .sync_slot(sync_slot)
  );

  // Return-to-zero: pulses live in the high half of each bit period.
  assign buf_ready = ~full;
  assign line_one  = data_slot &  cur_bit & tx_clk;
  assign line_zero = data_slot & ~cur_bit & tx_clk;
  assign ser_data  = data_slot & cur_bit;
  assign sync_n    = ~(sync_slot & ~tx_clk);

  always_comb begin
    a_r8_never_both: assert (!(line_one && line_zero)) else $error("R8: both pulse lines high");
  end

  a_r3_ready_falls: assert property (@(posedge tx_clk) disable iff (!rst_n)
    fourth_ev |=> !buf_ready) else $error("R3: ready stayed high");
  a_r4_ready_returns: assert property (@(posedge tx_clk) disable iff (!rst_n)
    xfer |=> buf_ready) else $error("R4: ready not restored at transfer");
  a_r9_gap_is_quiet: assert property (@(negedge tx_clk) disable iff (!rst_n)
    !data_slot |-> (!ser_data && sync_n)) else $error("R9: activity in gap");
endmodule

// File: tb/sim_arinc_word_tx.sv
`timescale 1ns/1ps
module sim_arinc_word_tx;
  logic       tx_clk = 1'b0;
  logic       rst_n  = 1'b0;
  logic       wr_n   = 1'b1;
  logic       first_sel = 1'b0;
  logic [7:0] din    = 8'h00;
  logic       par_en = 1'b0;
  logic       buf_ready, line_one, line_zero, ser_data, sync_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 tx_clk = ~tx_clk;

  arinc_word_tx u0 (
    .tx_clk(tx_clk), .rst_n(rst_n), .wr_n(wr_n), .first_sel(first_sel),
    .din(din), .par_en(par_en), .buf_ready(buf_ready), .line_one(line_one),
    .line_zero(line_zero), .ser_data(ser_data), .sync_n(sync_n)
  );

  // {label, byte2, byte3, byte4, par_en}
  localparam logic [32:0] VECS [5] = '{
    {8'h81, 8'h00, 8'hFF, 8'h55, 1'b0},
    {8'h81, 8'h00, 8'hFF, 8'h55, 1'b1},
    {8'hA5, 8'h3C, 8'h01, 8'h80, 1'b1},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    {8'hFF, 8'hFF, 8'hFF, 8'h7F, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected line order: label first, LSB first; count-based odd parity.
  function automatic logic [31:0] exp_stream(input logic [7:0] b0, input logic [7:0] b1,
                                             input logic [7:0] b2, input logic [7:0] b3,
                                             input logic par);
    logic [31:0] s;
    logic [7:0]  bb [4];
    int          ones;
    bb[0] = b0; bb[1] = b1; bb[2] = b2; bb[3] = b3;
    for (int k = 0; k < 32; k++) s[k] = bb[k/8][k%8];
    if (par) begin
      ones = $countones(s[30:0]);
      s[31] = (ones % 2 == 0);
    end
    return s;
  endfunction

  task automatic write_byte(input logic fs, input logic [7:0] d);
    @(negedge tx_clk);
    first_sel = fs; din = d; wr_n = 1'b0;
    repeat (2) @(negedge tx_clk);
    wr_n = 1'b1;
    repeat (3) @(negedge tx_clk);   // captured at the third rising edge
  endtask

  task automatic load_word(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3);
    write_byte(1'b1, b0);
    write_byte(1'b0, b1);
    write_byte(1'b0, b2);
    write_byte(1'b0, b3);
    chk(buf_ready == 1'b0, "R3", "ready after fourth byte", 32'(buf_ready), 32'd0);
  endtask

  task automatic send_bits(input logic [31:0] exp, input string rdy_req);
    for (int k = 0; k < 32; k++) begin
      @(posedge tx_clk); #1;
      if (k == 0) chk(buf_ready == 1'b1, rdy_req, "ready at bit 1", 32'(buf_ready), 32'd1);
      chk(line_one == exp[k],   "R8", $sformatf("line_one bit %0d", k),  32'(line_one),  32'(exp[k]));
      chk(line_zero == !exp[k], "R8", $sformatf("line_zero bit %0d", k), 32'(line_zero), 32'(!exp[k]));
      chk(ser_data == exp[k], (k == 31) ? "R7" : "R6", $sformatf("bit %0d", k),
          32'(ser_data), 32'(exp[k]));
      @(negedge tx_clk); #1;
      chk(!line_one && !line_zero, "R8", $sformatf("low half bit %0d", k),
          {30'd0, line_one, line_zero}, 32'd0);
      chk(sync_n == (k != 7), "R10", $sformatf("sync_n bit %0d", k), 32'(sync_n), 32'(k != 7));
      chk(ser_data == exp[k], "R9", $sformatf("held bit %0d", k), 32'(ser_data), 32'(exp[k]));
    end
  endtask

  task automatic check_gap(input int n, input logic rdy, input string req);
    for (int g = 0; g < n; g++) begin
      @(posedge tx_clk); #1;
      chk(!line_one && !line_zero && !ser_data, req, "gap quiet",
          {29'd0, line_one, line_zero, ser_data}, 32'd0);
      chk(buf_ready == rdy, req, "ready in gap", 32'(buf_ready), 32'(rdy));
      @(negedge tx_clk); #1;
      chk(sync_n == 1'b1, "R10", "sync_n in gap", 32'(sync_n), 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge tx_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ea, eb;
    // R1: reset state
    repeat (3) @(negedge tx_clk);
    #1;
    chk(buf_ready && !line_one && !line_zero && !ser_data && sync_n, "R1", "in reset",
        {27'd0, buf_ready, line_one, line_zero, ser_data, sync_n}, 32'h11);
    @(negedge tx_clk); rst_n = 1'b1;
    check_gap(10, 1'b1, "R1");

    // R11: byte 2 without label is dropped
    write_byte(1'b0, 8'h5A);
    chk(buf_ready == 1'b1, "R11", "orphan byte", 32'(buf_ready), 32'd1);

    // Table walk
    for (int v = 0; v < 5; v++) begin
      par_en = VECS[v][0];
      load_word(VECS[v][32:25], VECS[v][24:17], VECS[v][16:9], VECS[v][8:1]);
      send_bits(exp_stream(VECS[v][32:25], VECS[v][24:17], VECS[v][16:9], VECS[v][8:1],
                           VECS[v][0]), "R4");
      check_gap(4, 1'b1, "R1");
    end

    // R2: label rewrite restarts the word
    par_en = 1'b0;
    write_byte(1'b1, 8'h11);
    write_byte(1'b0, 8'h22);
    load_word(8'hC3, 8'h3C, 8'h0F, 8'hF0);
    send_bits(exp_stream(8'hC3, 8'h3C, 8'h0F, 8'hF0, 1'b0), "R2");
    check_gap(4, 1'b1, "R2");

    // R5: back-to-back with a queued word, plus an ignored write while full (R11)
    par_en = 1'b1;
    ea = exp_stream(8'h96, 8'h69, 8'hF0, 8'h0F, 1'b1);
    eb = exp_stream(8'h3A, 8'hC5, 8'h77, 8'h08, 1'b1);
    load_word(8'h96, 8'h69, 8'hF0, 8'h0F);
    fork
      begin
        send_bits(ea, "R4");
        check_gap(4, 1'b0, "R5");
        send_bits(eb, "R5");
        check_gap(8, 1'b1, "R11");
      end
      begin
        load_word(8'h3A, 8'hC5, 8'h77, 8'h08);
        write_byte(1'b1, 8'hFF);
        chk(buf_ready == 1'b0, "R5", "ready while queued", 32'(buf_ready), 32'd0);
      end
    join

    // R1: reset during a word aborts it
    par_en = 1'b0;
    load_word(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    repeat (10) @(posedge tx_clk);
    @(negedge tx_clk); rst_n = 1'b0; #1;
    chk(buf_ready && !line_one && !line_zero && !ser_data && sync_n, "R1", "reset mid-word",
        {27'd0, buf_ready, line_one, line_zero, ser_data, sync_n}, 32'h11);
    @(negedge tx_clk); rst_n = 1'b1;
    check_gap(40, 1'b1, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule